// File: doc/BRIEF.md
# Sign-Magnitude Trip-Point Comparator

This block holds five programmable 16-bit thresholds. On each new-sample strobe it checks every threshold against a live measurement word and produces one registered trip flag per threshold. A power-mode controller uses these flags to decide when to enter or leave low-power states.

All words use the same left-justified sign-magnitude format. Bit 15 carries the polarity and bits 14 down to 0 carry the magnitude. A converter running at a resolution of N bits fills only bits 14 down to 15-N. The comparison uses the magnitude alone and looks only at the bit positions that the current resolution makes valid.

Each threshold lane has a fixed measurement source. Two lanes watch the current, two watch the pack voltage, and one watches either the pack voltage or an auxiliary voltage, chosen by a select input. Each lane is switched on or off by its own enable bit.

Top module: `trip_compare_top`

## Requirements
- R1: A write with `wr_en` high to word address 0x60 + 4·i (i = 0..4) loads `wr_data` into threshold i at the next rising edge. Threshold i drives `trip_flag[i]`.
- R2: On an edge where `sample_stb` is high and lane i is enabled, `trip_flag[i]` becomes 1 if the masked measured magnitude is greater than or equal to the masked threshold magnitude, and 0 otherwise. The comparison uses the threshold value held before any write in that same cycle.
- R3: With resolution N (`res_bits`, 0..15), only magnitude bits 14 down to 15-N of both operands take part in the comparison, and lower bits are treated as zero. With N = 0 no bit takes part, so every enabled lane trips.
- R4: Bit 15 (the sign, 0 = positive, 1 = negative) of both the threshold and the measurement has no effect on any flag.
- R5: When `trip_en[i]` is low on a rising edge, `trip_flag[i]` is 0 after that edge, whether or not the strobe is present.
- R6: When a lane is enabled and `sample_stb` is low, its flag keeps its previous value.
- R7: A write to any address other than the five threshold addresses, or with `wr_en` low, changes no threshold.
- R8: Reset (`rst_n` low, synchronous) clears all thresholds to zero and all flags to 0.
- R9: Lanes 0 and 1 compare against `meas_cur`, and lanes 2 and 4 compare against `meas_pack`. Lane 3 compares against `meas_pack` when `aux_sel` is 0 and against `meas_aux` when `aux_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Threshold write strobe |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 16 | Threshold value, sign-magnitude |
| sample_stb | input | 1 | New-sample strobe, triggers comparison |
| res_bits | input | 4 | Converter resolution N |
| trip_en | input | 5 | Per-lane comparison enable |
| aux_sel | input | 1 | Lane 3 source: 0 pack, 1 auxiliary |
| meas_cur | input | 16 | Current measurement |
| meas_pack | input | 16 | Pack-voltage measurement |
| meas_aux | input | 16 | Auxiliary-voltage measurement |
| trip_flag | output | 5 | Registered trip flags, one per lane |

## Verification
The bench tests a threshold that differs from the measurement only below the resolution cut-off. A design that compares unmasked bits would miss that trip. It tests opposite signs on otherwise equal words, where a design that compares signed values or includes bit 15 would clear the flag. It tests exact equality, where a design using a strict greater-than comparison would fail to trip. It also covers a write and a strobe in the same cycle, N = 0, writes to near-miss addresses, lane 3 under both select values, and dropping an enable without a strobe. A design that reads the new threshold early, decodes addresses loosely, routes lane 3 wrongly, or clears flags only on a strobe would show a flag mismatch in one of these cases.

// File: rtl/trip_pkg.sv
package trip_pkg;
    localparam int W     = 16;
    localparam int MAGW  = W - 1;
    localparam int NTRIP = 5;
    localparam int RES_W = $clog2(W);

    typedef logic [W-1:0] word_t;
    typedef logic [NTRIP-1:0][W-1:0] thr_arr_t;

    typedef enum logic [1:0] {
        SRC_CUR,
        SRC_PACK,
        SRC_SEL
    } src_e;

    // Fixed measurement source of each lane
    function automatic src_e lane_src(input int idx);
        case (idx)
            0, 1:    return SRC_CUR;
            3:       return SRC_SEL;
            default: return SRC_PACK;
        endcase
    endfunction

    // Keep only the magnitude bits valid at resolution n
    function automatic logic [MAGW-1:0] mag_mask(input logic [MAGW-1:0] m,
                                                 input logic [RES_W-1:0] n);
        logic [MAGW-1:0] r;
        r = '0;
        for (int k = 0; k < MAGW; k++) begin
            r[k] = m[k] & (k >= (MAGW - int'(n)));
        end
        return r;
    endfunction
endpackage

// File: rtl/trip_thr_regs.sv
module trip_thr_regs
    import trip_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h60,
    parameter int                STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    output thr_arr_t          thr_o
);
    typedef struct packed {
        thr_arr_t thr;
    } regs_t;

    regs_t            r_d, r_q;
    logic [NTRIP-1:0] hit;

    for (genvar g = 0; g < NTRIP; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(int'(BASE) + g * STRIDE);
        assign hit[g] = wr_en && (wr_addr == LANE_ADDR);

        // R1: a decoded write lands in its own slot
        a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> (r_q.thr[g] == $past(wr_data)));
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NTRIP; i++) begin
            if (hit[i]) r_d.thr[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign thr_o = r_q.thr;

    // R7: no decoded write leaves every threshold untouched
    a_r7_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> $stable(r_q.thr));
endmodule

// File: rtl/trip_lane.sv
module trip_lane
    import trip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stb_i,
    input  logic [RES_W-1:0] res_i,
    input  word_t            meas_i,
    input  word_t            thr_i,
    output logic             flag_o
);
    typedef struct packed {
        logic flag;
    } lane_t;

    lane_t           l_d, l_q;
    logic [MAGW-1:0] meas_m, thr_m;

    always_comb begin
        meas_m = mag_mask(meas_i[MAGW-1:0], res_i);
        thr_m  = mag_mask(thr_i[MAGW-1:0], res_i);
        l_d    = l_q;
        if (!en_i)      l_d.flag = 1'b0;
        else if (stb_i) l_d.flag = (meas_m >= thr_m);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign flag_o = l_q.flag;

    // R5: disabled lane is low after the edge
    a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !flag_o);

    // R6: no strobe, flag holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stb_i) |=> $stable(flag_o));

    // R2: equal raw magnitudes must trip
    a_r2_equal_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stb_i && (meas_i[MAGW-1:0] == thr_i[MAGW-1:0])) |=> flag_o);

    // R4: opposite signs with equal magnitudes still trip
    a_r4_sign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stb_i && (meas_i[W-1] != thr_i[W-1]) &&
         (meas_i[MAGW-1:0] == thr_i[MAGW-1:0])) |=> flag_o);

    // R3: resolution zero leaves nothing to compare
    a_r3_zero_res_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stb_i && (res_i == '0)) |=> flag_o);
endmodule

// File: rtl/trip_compare_top.sv
module trip_compare_top
    import trip_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h60,
    parameter int                ADDR_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              sample_stb,
    input  logic [RES_W-1:0]  res_bits,
    input  logic [NTRIP-1:0]  trip_en,
    input  logic              aux_sel,
    input  logic [W-1:0]      meas_cur,
    input  logic [W-1:0]      meas_pack,
    input  logic [W-1:0]      meas_aux,
    output logic [NTRIP-1:0]  trip_flag
);
    thr_arr_t thr;

    trip_thr_regs #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE_ADDR),
        .STRIDE (ADDR_STRIDE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .thr_o   (thr)
    );

    for (genvar g = 0; g < NTRIP; g++) begin : g_lane
        localparam src_e SRC = lane_src(g);
        word_t sel;

        // R9: per-lane source routing
        if (SRC == SRC_CUR) begin : g_cur
            assign sel = meas_cur;
        end else if (SRC == SRC_PACK) begin : g_pack
            assign sel = meas_pack;
        end else begin : g_sel
            assign sel = aux_sel ? meas_aux : meas_pack;
        end

        trip_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (trip_en[g]),
            .stb_i  (sample_stb),
            .res_i  (res_bits),
            .meas_i (sel),
            .thr_i  (thr[g]),
            .flag_o (trip_flag[g])
        );
    end
endmodule

// File: tb/test_trip_compare_top.sv
module test_trip_compare_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sample_stb = 1'b0;
    logic [3:0]  res_bits = 4'd15;
    logic [4:0]  trip_en = '0;
    logic        aux_sel = 1'b0;
    logic [15:0] meas_cur = '0, meas_pack = '0, meas_aux = '0;
    logic [4:0]  trip_flag;

    logic [15:0] m_thr [5];
    logic [4:0]  m_flag;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trip_compare_top i_trip_compare_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_stb(sample_stb), .res_bits(res_bits),
        .trip_en(trip_en), .aux_sel(aux_sel), .meas_cur(meas_cur),
        .meas_pack(meas_pack), .meas_aux(meas_aux), .trip_flag(trip_flag)
    );

    function automatic bit ge_ref(input logic [15:0] m, input logic [15:0] t, input int n);
        int sh;
        sh = 15 - n;
        return ((m & 16'h7FFF) >> sh) >= ((t & 16'h7FFF) >> sh);
    endfunction

    function automatic logic [15:0] src_ref(input int i);
        if (i < 2)  return meas_cur;
        if (i == 3) return aux_sel ? meas_aux : meas_pack;
        return meas_pack;
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (trip_flag !== m_flag) begin
            n_fail++;
            $display("FAIL %s: trip_flag=%b expected %b", tag, trip_flag, m_flag);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        for (int i = 0; i < 5; i++) begin
            if (!rst_n)          m_flag[i] = 1'b0;
            else if (!trip_en[i]) m_flag[i] = 1'b0;
            else if (sample_stb) m_flag[i] = ge_ref(src_ref(i), m_thr[i], int'(res_bits));
        end
        for (int i = 0; i < 5; i++) begin
            if (!rst_n) m_thr[i] = '0;
            else if (wr_en && wr_addr == 8'(8'h60 + 4 * i)) m_thr[i] = wr_data;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sample_stb = 1'b0;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input string tag);
        sample_stb = 1'b1;
        tick(tag);
        sample_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_flag = '0;
        for (int i = 0; i < 5; i++) m_thr[i] = '0;
        @(negedge clk);
        tick("R8 flags low in reset");
        tick("R8 flags low in reset");
        rst_n = 1'b1;
        tick("R8 flags low after reset");

        // R8: zero thresholds trip on zero measurements
        trip_en = 5'h1F; res_bits = 4'd15;
        strobe("R8 zero thresholds trip");

        // R1: load all lanes, no strobe so flags hold (R6)
        wr(8'h60, 16'h2000, "R1 R6 write lane0");
        wr(8'h64, 16'h8100, "R1 R6 write lane1");
        wr(8'h68, 16'h4000, "R1 R6 write lane2");
        wr(8'h6C, 16'h6000, "R1 R6 write lane3");
        wr(8'h70, 16'h7FFF, "R1 R6 write lane4");
        strobe("R1 R2 all below threshold");

        meas_cur = 16'h2000; meas_pack = 16'h4000;
        strobe("R2 equality trips");
        meas_cur = 16'h1FFF; meas_pack = 16'h3FFF;
        strobe("R2 one below");

        // R4: signs ignored
        meas_cur = 16'hA000; meas_pack = 16'hC000;
        strobe("R4 negative measurement");
        meas_cur = 16'h0100;
        strobe("R4 negative threshold lane1");

        // R3: masking
        wr(8'h60, 16'h27FF, "R1 write lane0 low bits");
        meas_cur = 16'h2001; res_bits = 4'd4;
        strobe("R3 low bits masked");
        res_bits = 4'd15;
        strobe("R3 full resolution");
        res_bits = 4'd0; meas_cur = 16'h0000; meas_pack = 16'h0000;
        strobe("R3 zero resolution trips");
        res_bits = 4'd15;

        // R9: lane 3 source select
        meas_pack = 16'h0010; meas_aux = 16'h7000; aux_sel = 1'b1;
        strobe("R9 aux source");
        aux_sel = 1'b0;
        strobe("R9 pack source");

        // R7: near-miss and disabled writes
        wr(8'h61, 16'h0000, "R7 miss write");
        wr_en = 1'b0; wr_addr = 8'h68; wr_data = 16'h0000;
        tick("R7 no wr_en");
        meas_cur = 16'h2000;
        strobe("R7 thresholds unchanged");

        // R2: write and strobe in one cycle use old value
        wr_en = 1'b1; wr_addr = 8'h60; wr_data = 16'h7FFF; sample_stb = 1'b1;
        tick("R2 same-cycle write");
        wr_en = 1'b0; sample_stb = 1'b0;

        // R5: disable without strobe
        meas_cur = 16'h7FFF; meas_pack = 16'h7FFF;
        strobe("R5 setup");
        trip_en = 5'b01010;
        tick("R5 disable clears");
        trip_en = 5'h1F;

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            wr_en = ($urandom % 4) == 0;
            wr_addr = (($urandom % 4) == 0) ? 8'($urandom) : 8'(8'h60 + 4 * ($urandom % 5));
            wr_data = 16'($urandom);
            sample_stb = $urandom % 2;
            if (($urandom % 8) == 0) trip_en = 5'($urandom);
            res_bits = 4'($urandom);
            aux_sel = $urandom % 2;
            meas_cur  = (($urandom % 2) == 0) ? (m_thr[$urandom % 2] ^ 16'($urandom % 64)) : 16'($urandom);
            meas_pack = (($urandom % 2) == 0) ? (m_thr[2] ^ 16'($urandom % 64)) : 16'($urandom);
            meas_aux  = (($urandom % 2) == 0) ? (m_thr[3] ^ 16'h8000) : 16'($urandom);
            tick("R1 R2 R3 R4 R5 R6 R7 R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule